// File: doc/BRIEF.md
# Self-Loading Tape Image Streamer

This block turns a range of memory into the byte stream of a punched tape that loads itself. A single start pulse, together with a low and a high 16-bit address, launches a job. The block first reads the whole range once to form an XOR checksum. It then streams out five segments in a fixed order: a blank leader, a small loader image, a second leader, the memory bytes, and a closing leader. The loader image comes from an internal ROM. The range bounds and the checksum are written into it while it streams, so the loader on the tape knows where to put the data and how to verify it.

Memory is read through a synchronous port with one cycle of latency. Bytes leave on a valid/ready stream, and a one-cycle done pulse marks the end of a job. A request whose low address lies below a configured floor, or whose high address lies below its low address, is refused with a one-cycle error pulse. A refused request reads no memory and emits no bytes.

Top module: `tape_image_streamer`

## Requirements
- R1: After reset, and after a reset that interrupts a job, `out_valid`, `done`, `err` and `mem_rd` are all low.
- R2: A start whose `lo_addr` is below `MIN_ADDR` raises `err` for exactly the one cycle after the start. It issues no memory read and presents no output byte.
- R3: A start whose `hi_addr` is less than its `lo_addr` is refused in the same way as R2: a single-cycle `err`, no reads and no output.
- R4: An accepted job reads each address from `lo_addr` up to `hi_addr` exactly once, in ascending order, to form the checksum. All of these reads complete before the first output byte. A second ascending pass then reads each address exactly once more, so a job makes 2·(hi−lo+1) reads in total. Read data is taken one cycle after `mem_rd`.
- R5: The stream consists of `LEADER_LEN` zero bytes, then 64 loader bytes, then `LEADER_LEN` zero bytes, then the memory bytes from `lo_addr` through `hi_addr`, then `LEADER_LEN` zero bytes.
- R6: Loader byte at offset i (0..63) equals (29·i + 71) mod 256, except at the patched offsets of R7.
- R7: The loader image is based at address 0x80. Loader offset 10 (address 0x8A) carries `lo_addr[15:8]` and offset 11 carries `lo_addr[7:0]`. Offset 14 (0x8E) carries `hi_addr[15:8]` and offset 15 carries `hi_addr[7:0]`. Offset 19 (0x93) carries the XOR, starting from zero, of every memory byte from `lo_addr` through `hi_addr`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last trailing-leader byte is accepted. A new start is accepted from then on.
- R10: A start pulse that arrives while a job is running has no effect: the running job's stream and reads are unchanged and no `err` is raised.
- R11: A range that ends at 0xFFFF is read without wrapping past the high address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job request |
| lo_addr | input | 16 | First address of the range |
| hi_addr | input | 16 | Last address of the range (inclusive) |
| err | output | 1 | One-cycle pulse for a refused request |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_data | input | 8 | Read data, valid one cycle after `mem_rd` |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte present |
| out_ready | input | 1 | Stream byte accepted when high with `out_valid` |
| done | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
The bench builds the block with `LEADER_LEN` = 4 and `MIN_ADDR` = 0x0010. Short leaders keep every job to a few hundred cycles while still crossing all five segment boundaries under several backpressure patterns. A low floor lets jobs sit exactly on the floor, one below it, and at the top of the address space ending at 0xFFFF. Ranges of one byte and of tens of bytes exercise the checksum pass, the patched loader bytes, and the handoff from the data pass into the closing leader.

// File: rtl/tis_pkg.sv
// Shared definitions for the tape image streamer.
// Assumes 16-bit addresses and byte-wide memory and stream.
package tis_pkg;
    localparam int ADDR_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int LOADER_LEN  = 64;
    localparam int LOADER_BASE = 'h80;
    // Patch positions are tied to the loader code that reads them.
    localparam int LO_PATCH    = 'h8A - LOADER_BASE;
    localparam int HI_PATCH    = 'h8E - LOADER_BASE;
    localparam int CS_PATCH    = 'h93 - LOADER_BASE;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SUM,
        PH_SUM_TAIL,
        PH_LEAD_A,
        PH_LOADER,
        PH_LEAD_B,
        PH_DATA,
        PH_LEAD_C,
        PH_DRAIN
    } phase_t;
endpackage

// File: rtl/tis_range_gate.sv
// Decides whether a requested address range may be imaged.
// Assumes inputs are sampled only with the start pulse; purely combinational.
module tis_range_gate #(
    parameter logic [15:0] MIN_ADDR = 16'h0100
) (
    input  logic [15:0] lo,
    input  logic [15:0] hi,
    output logic        ok
);
    // Accept only ranges at or above the floor and not reversed.
    always_comb begin
        ok = (lo >= MIN_ADDR) && (hi >= lo);
    end
endmodule

// File: rtl/tis_xor_acc.sv
// Byte XOR accumulator for the checksum pass.
// Assumes clr and en are never high together.
module tis_xor_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] acc
);
    // Fold each returned byte into the running checksum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc ^ din;
        end
    end

    // R4
    clr_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && en));
endmodule

// File: rtl/tis_loader_rom.sv
// Loader image source with live patching of bounds and checksum.
// Assumes idx < LOADER_LEN; contents are computed, not stored.
module tis_loader_rom
    import tis_pkg::*;
#(
    parameter int IDX_W = $clog2(LOADER_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      lo,
    input  logic [15:0]      hi,
    input  logic [7:0]       csum,
    output logic [7:0]       byte_o
);
    logic [7:0] base;

    // Select the computed image byte or one of the five patch values.
    always_comb begin
        base = 8'(32'(idx) * 29 + 71);
        case (32'(idx))
            LO_PATCH:     byte_o = lo[15:8];
            LO_PATCH + 1: byte_o = lo[7:0];
            HI_PATCH:     byte_o = hi[15:8];
            HI_PATCH + 1: byte_o = hi[7:0];
            CS_PATCH:     byte_o = csum;
            default:      byte_o = base;
        endcase
    end
endmodule

// File: rtl/tape_image_streamer.sv
// Streams a self-loading tape image of a memory range:
// leader, patched loader, leader, data, leader.
// Assumes a memory read port with one cycle of latency and a
// valid/ready sink; the first pass builds the checksum.
module tape_image_streamer
    import tis_pkg::*;
#(
    parameter int          LEADER_LEN = 50,
    parameter logic [15:0] MIN_ADDR   = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] lo_addr,
    input  logic [15:0] hi_addr,
    output logic        err,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_data,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        done
);
    localparam int SEG_MAX = (LEADER_LEN > LOADER_LEN) ? LEADER_LEN : LOADER_LEN;
    localparam int CNT_W   = $clog2(SEG_MAX + 1);
    localparam int IDX_W   = $clog2(LOADER_LEN);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEADER_LEN - 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOADER_LEN - 1);

    phase_t            phase_q;
    logic [15:0]       ptr_q, lo_q, hi_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              data_pend_q, sum_pend_q;
    logic              range_ok, slot_free, fill_ok, rd_sum, rd_data, last_addr;
    logic              seg_end, start_ok;
    logic [7:0]        csum, rom_byte;

    tis_range_gate #(.MIN_ADDR(MIN_ADDR)) u_gate (
        .lo (lo_addr),
        .hi (hi_addr),
        .ok (range_ok)
    );

    tis_xor_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .en    (sum_pend_q),
        .din   (mem_data),
        .acc   (csum)
    );

    tis_loader_rom #(.IDX_W(IDX_W)) u_rom (
        .idx    (cnt_q[IDX_W-1:0]),
        .lo     (lo_q),
        .hi     (hi_q),
        .csum   (csum),
        .byte_o (rom_byte)
    );

    // Derive read strobes and output-slot availability.
    always_comb begin
        start_ok  = (phase_q == PH_IDLE) && start && range_ok;
        slot_free = !out_valid || out_ready;
        fill_ok   = slot_free && !data_pend_q;
        rd_sum    = (phase_q == PH_SUM);
        rd_data   = (phase_q == PH_DATA) && slot_free && !data_pend_q;
        mem_rd    = rd_sum || rd_data;
        mem_addr  = ptr_q;
        last_addr = (ptr_q == hi_q);
        seg_end   = (phase_q == PH_LOADER) ? (cnt_q == LOAD_LAST) : (cnt_q == LEAD_LAST);
    end

    // Sequence the job phases and own the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            ptr_q       <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            cnt_q       <= '0;
            data_pend_q <= 1'b0;
            sum_pend_q  <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            err         <= 1'b0;
            done        <= 1'b0;
        end else begin
            err         <= 1'b0;
            done        <= 1'b0;
            data_pend_q <= rd_data;
            sum_pend_q  <= rd_sum;
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (data_pend_q) begin
                out_valid <= 1'b1;
                out_data  <= mem_data;
            end
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (range_ok) begin
                            lo_q    <= lo_addr;
                            hi_q    <= hi_addr;
                            ptr_q   <= lo_addr;
                            phase_q <= PH_SUM;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                PH_SUM: begin
                    if (last_addr) phase_q <= PH_SUM_TAIL;
                    else           ptr_q   <= ptr_q + 16'd1;
                end
                PH_SUM_TAIL: begin
                    cnt_q   <= '0;
                    phase_q <= PH_LEAD_A;
                end
                PH_LEAD_A, PH_LOADER, PH_LEAD_B, PH_LEAD_C: begin
                    if (fill_ok) begin
                        out_valid <= 1'b1;
                        out_data  <= (phase_q == PH_LOADER) ? rom_byte : 8'h00;
                        if (seg_end) begin
                            cnt_q <= '0;
                            case (phase_q)
                                PH_LEAD_A: phase_q <= PH_LOADER;
                                PH_LOADER: phase_q <= PH_LEAD_B;
                                PH_LEAD_B: begin
                                    phase_q <= PH_DATA;
                                    ptr_q   <= lo_q;
                                end
                                default:   phase_q <= PH_DRAIN;
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (rd_data) begin
                        if (last_addr) phase_q <= PH_LEAD_C;
                        else           ptr_q   <= ptr_q + 16'd1;
                    end
                end
                PH_DRAIN: begin
                    if (out_valid && out_ready) begin
                        done    <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid && !mem_rd);

    // R4
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr >= lo_q) && (mem_addr <= hi_q));

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && (mem_addr == 16'hFFFF) |=> !mem_rd || (mem_addr != 16'h0000));
endmodule

// File: tb/test_tape_image_streamer.sv
module test_tape_image_streamer;
    localparam int          LEAD  = 4;
    localparam logic [15:0] FLOOR = 16'h0010;
    localparam int          LDR   = 64;
    localparam int          NVEC  = 7;
    // {lo, hi, ready mode, refusal kind: 0 none, 1 floor, 2 reversed}
    localparam logic [39:0] VECS [NVEC] = '{
        {16'h1234, 16'h1240, 4'd0, 4'd0},
        {16'h0010, 16'h0010, 4'd1, 4'd0},
        {16'h0300, 16'h031F, 4'd2, 4'd0},
        {16'h000F, 16'h0020, 4'd0, 4'd1},
        {16'h0100, 16'h00FF, 4'd0, 4'd2},
        {16'hFFF0, 16'hFFFF, 4'd1, 4'd0},
        {16'h4A5B, 16'h4A62, 4'd3, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] lo_addr = '0, hi_addr = '0;
    logic        err, mem_rd, out_valid, done;
    logic        out_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data = '0, out_data;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    tape_image_streamer #(.LEADER_LEN(LEAD), .MIN_ADDR(FLOOR)) i_tape_image_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .lo_addr(lo_addr), .hi_addr(hi_addr),
        .err(err), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .done(done)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
    endfunction

    // Memory model with one cycle of read latency.
    always @(posedge clk) if (mem_rd) mem_data <= memf(mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_job(input logic [15:0] lo, input logic [15:0] hi,
                           input int mode, input int refuse, input bit inject);
        int n = int'(hi) - int'(lo) + 1;
        int exp_len = 3 * LEAD + LDR + n;
        logic [7:0] cs = '0;
        logic [7:0] ev, prev = '0;
        int got = 0, rd_cnt = 0, cyc = 0;
        int b5 = 0, b6 = 0, b7 = 0, hold_bad = 0, rd_bad = 0, err_seen = 0, ord_bad = 0;
        int f_act = 0, f_exp = 0, done_len = -1, outs = 0;
        bit stalled = 0, seen_done = 0;
        string rtag;
        if (refuse == 2) rtag = "R3"; else rtag = "R2";
        if (refuse == 0) for (int i = 0; i < n; i++) cs ^= memf(lo + 16'(i));
        @(negedge clk);
        lo_addr = lo; hi_addr = hi; start = 1'b1;
        if (refuse != 0) begin
            @(negedge clk);
            start = 1'b0;
            #1;
            check(err === 1'b1, rtag, "err pulse after refused start", int'(err), 1);
            for (int k = 0; k < 20; k++) begin
                @(negedge clk); #1;
                if (mem_rd) rd_cnt++;
                if (out_valid) outs++;
                if (err) err_seen++;
            end
            check(rd_cnt == 0 && outs == 0, rtag, "reads+outputs after refusal", rd_cnt + outs, 0);
            check(err_seen == 0, rtag, "err longer than one cycle", err_seen, 0);
            return;
        end
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (inject && cyc == 20) begin start = 1'b1; lo_addr = 16'h0040; hi_addr = 16'h0048; end
            if (inject && cyc == 21) begin start = 1'b1; lo_addr = 16'h0005; hi_addr = 16'h0001; end
            if (inject && cyc == 22) start = 1'b0;
            case (mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 2) == 1;
                2:       out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 4) == 0;
            endcase
            #1;
            if (err) err_seen++;
            if (stalled && !(out_valid && out_data == prev)) hold_bad++;
            if (mem_rd) begin
                if (rd_cnt >= 2 * n || mem_addr != lo + 16'(rd_cnt % n)) rd_bad++;
                rd_cnt++;
            end
            if (out_valid && out_ready) begin
                if (got == 0 && rd_cnt < n) ord_bad++;
                if (got < LEAD || (got >= LEAD + LDR && got < 2 * LEAD + LDR) || got >= 2 * LEAD + LDR + n) begin
                    if (out_data != 8'h00) begin b5++; f_act = out_data; f_exp = 0; end
                end else if (got < LEAD + LDR) begin
                    int i = got - LEAD;
                    ev = 8'(i * 29 + 71);
                    if (i == 10) ev = lo[15:8];
                    if (i == 11) ev = lo[7:0];
                    if (i == 14) ev = hi[15:8];
                    if (i == 15) ev = hi[7:0];
                    if (i == 19) ev = cs;
                    if (out_data != ev) begin
                        if (i == 10 || i == 11 || i == 14 || i == 15 || i == 19) b7++; else b6++;
                        f_act = out_data; f_exp = ev;
                    end
                end else begin
                    ev = memf(lo + 16'(got - 2 * LEAD - LDR));
                    if (out_data != ev) begin b5++; f_act = out_data; f_exp = ev; end
                end
                got++;
            end
            if (done) begin seen_done = 1; done_len = got; end
            stalled = out_valid && !out_ready;
            prev = out_data;
            cyc++;
        end
        check(b5 == 0, "R5", "leader/data byte", f_act, f_exp);
        check(b6 == 0, "R6", "loader image byte", f_act, f_exp);
        check(b7 == 0, "R7", "patched bound/checksum byte", f_act, f_exp);
        check(got == exp_len, "R5", "stream length", got, exp_len);
        check(rd_bad == 0 && rd_cnt == 2 * n && ord_bad == 0,
              (hi == 16'hFFFF) ? "R11" : "R4", "read count", rd_cnt, 2 * n);
        check(hold_bad == 0, "R8", "held byte changed", hold_bad, 0);
        check(done_len == exp_len, "R9", "done after last byte", done_len, exp_len);
        @(negedge clk); #1;
        check(done == 1'b0, "R9", "done width", int'(done), 0);
        check(err_seen == 0, inject ? "R10" : "R2", "spurious err", err_seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !done && !err && !mem_rd, "R1", "idle outputs in reset",
              {out_valid, done, err, mem_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!out_valid && !done && !err && !mem_rd, "R1", "idle outputs after reset",
              {out_valid, done, err, mem_rd}, 0);
        for (int v = 0; v < NVEC; v++)
            run_job(VECS[v][39:24], VECS[v][23:8], int'(VECS[v][7:4]), int'(VECS[v][3:0]), 1'b0);
        // R10: start pulses during a running job
        run_job(16'h0200, 16'h020A, 2, 0, 1'b1);
        // R1: reset in the middle of a job
        @(negedge clk);
        lo_addr = 16'h0500; hi_addr = 16'h0520; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(!out_valid && !done && !err && !mem_rd, "R1", "outputs after mid-job reset",
              {out_valid, done, err, mem_rd}, 0);
        rst_n = 1'b1;
        run_job(16'h0777, 16'h077C, 0, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule